// File: doc/BRIEF.md
# STS-1 Transmit Scrambler with Path AIS Insertion

This stage sits at the end of an STS-1 transmit path. It takes one byte per valid cycle, tagged with its row (1 to 9) and column (1 to 90) in the 9 by 90 frame. It optionally forces path AIS, then applies the frame-synchronous SONET scrambler and returns the byte one clock later with its tags. Parity generation, pointer processing and parallel-to-serial conversion happen elsewhere. This block only changes byte values.

The scrambler is a seven-stage shift register for the polynomial 1 + x^6 + x^7. It is loaded with all ones at the first byte after C1, so the keystream is aligned to the frame. The three leading bytes of row 1 (both framing bytes and C1) always pass through unchanged. When path AIS is requested, the pointer bytes H1 to H3 and every payload column are replaced by all ones before the keystream is applied. With scrambling turned off, the data path is transparent apart from the AIS overwrite.

Top module: `sts1_tx_scrambler`

## Requirements
- R1: Keystream bits follow x(n) = x(n-6) xor x(n-7). Each byte uses 8 consecutive bits, and the first bit lands in bit 7 (the MSB). The byte is XORed with its keystream byte when scrambling is enabled.
- R2: The byte at row 1, column 4 restarts the keystream from seven ones. That byte is XORed with 0xFE, and the next three bytes with 0x04, 0x18 and 0x51.
- R3: Row 1 columns 1, 2 and 3 (A1, A2, C1) leave unchanged, whatever the scramble and AIS inputs are.
- R4: With scrEn low and aisEn low, every byte leaves unchanged.
- R5: With aisEn high, row 4 columns 1 to 3 and all of columns 4 to 90 in every row are replaced by 0xFF before scrambling. Other transport overhead bytes keep their data.
- R6: Output is registered one clock after input. outValid follows inValid with one cycle of delay, and outRow/outCol repeat the input tags of that byte.
- R7: The keystream advances only on valid bytes. Idle cycles between bytes do not shift it.
- R8: Reset clears outValid and outByte and sets the scrambler to all ones. A byte scrambled before any restart position is therefore XORed with 0xFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte present this cycle |
| inByte | input | 8 | Input data byte |
| inRow | input | 4 | Row tag, 1 to 9 |
| inCol | input | 7 | Column tag, 1 to 90 |
| scrEn | input | 1 | Apply the scrambler |
| aisEn | input | 1 | Force path AIS |
| outValid | output | 1 | Output byte present |
| outByte | output | 8 | Processed byte |
| outRow | output | 4 | Delayed row tag |
| outCol | output | 7 | Delayed column tag |

## Verification
The bench builds the block with its default geometry: 9 rows, 90 columns, 3 overhead columns and the pointer in row 4. With these values it can drive complete 810-byte frames, so the restart at row 1 column 4 is reached once per frame. The AIS boundary between overhead and payload columns, and the wrap from the last byte of one frame into the framing bytes of the next, are also exercised. Frames with idle gaps confirm that the keystream position depends only on valid bytes.

// File: rtl/sts1_scr_pkg.sv
package sts1_scr_pkg;

  localparam int BYTE_W  = 8;
  // Scrambler x^7 + x^6 + 1: register length and inner tap
  localparam int SCR_LEN = 7;
  localparam int SCR_TAP = 6;

  typedef struct packed {
    logic take;       // a valid byte is present
    logic seed;       // restart keystream at this byte
    logic forceOnes;  // path AIS overwrite
    logic applyScr;   // XOR keystream into this byte
  } strobeT;

endpackage

// File: rtl/sts1_scr_ctrl.sv
module sts1_scr_ctrl
  import sts1_scr_pkg::*;
#(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 7,
  parameter int OH_COLS = 3,
  parameter int PTR_ROW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [ROW_W-1:0] inRow,
  input  logic [COL_W-1:0] inCol,
  input  logic             scrEn,
  input  logic             aisEn,
  output strobeT           strb
);

  localparam logic [COL_W-1:0] LAST_OH_COL = COL_W'(OH_COLS);
  localparam logic [COL_W-1:0] SEED_COL    = COL_W'(OH_COLS + 1);
  localparam logic [ROW_W-1:0] FIRST_ROW   = ROW_W'(1);
  localparam logic [ROW_W-1:0] PTR_ROW_V   = ROW_W'(PTR_ROW);

  logic inOhCols;
  logic skipHit;
  logic seedHit;
  logic aisHit;

  always_comb begin
    inOhCols = (inCol <= LAST_OH_COL);
    skipHit  = (inRow == FIRST_ROW) && inOhCols;
    seedHit  = (inRow == FIRST_ROW) && (inCol == SEED_COL);
    aisHit   = aisEn && (!inOhCols || (inRow == PTR_ROW_V));
  end

  always_comb begin
    strb.take      = inValid;
    strb.seed      = inValid && seedHit;
    strb.forceOnes = inValid && aisHit;
    strb.applyScr  = inValid && scrEn && !skipHit;
  end

  // R2/R3: the restart byte is never one of the unscrambled bytes
  p_seed_vs_skip_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({seedHit, skipHit}));

  // R3: framing and C1 bytes never get the AIS overwrite
  p_no_ais_on_framing_r3: assert property (@(posedge clk) disable iff (!rstN)
    skipHit |-> !aisHit);

endmodule

// File: rtl/sts1_scr_datapath.sv
module sts1_scr_datapath
  import sts1_scr_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [COL_W-1:0]  inCol,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol
);

  logic [SCR_LEN-1:0] scrState;
  logic [SCR_LEN-1:0] walk;
  logic [SCR_LEN-1:0] endState;
  logic [BYTE_W-1:0]  mask;
  logic [BYTE_W-1:0]  preScr;
  logic [BYTE_W-1:0]  nextByte;

  // Walk the register BYTE_W steps; first bit out is the MSB
  always_comb begin
    walk = strb.seed ? {SCR_LEN{1'b1}} : scrState;
    for (int k = 0; k < BYTE_W; k++) begin
      mask[BYTE_W-1-k] = walk[SCR_LEN-1];
      walk = {walk[SCR_LEN-2:0], walk[SCR_LEN-1] ^ walk[SCR_TAP-1]};
    end
    endState = walk;
  end

  // AIS overwrite first, then scrambling
  always_comb begin
    preScr   = strb.forceOnes ? {BYTE_W{1'b1}} : inByte;
    nextByte = strb.applyScr ? (preScr ^ mask) : preScr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
      outRow   <= '0;
      outCol   <= '0;
      scrState <= {SCR_LEN{1'b1}};
    end else begin
      outValid <= strb.take;
      if (strb.take) begin
        outByte  <= nextByte;
        outRow   <= inRow;
        outCol   <= inCol;
        scrState <= endState;
      end
    end
  end

  // R7: the scrambler position holds across idle cycles
  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.take |=> $stable(scrState));

  // R2: the restart byte receives the leading keystream byte 0xFE
  p_seed_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.seed && strb.applyScr && !strb.forceOnes)
      |=> outByte == ($past(inByte) ^ 8'hFE));

endmodule

// File: rtl/sts1_tx_scrambler.sv
module sts1_tx_scrambler
  import sts1_scr_pkg::*;
#(
  parameter int NUM_ROWS = 9,
  parameter int NUM_COLS = 90,
  parameter int OH_COLS  = 3,
  parameter int PTR_ROW  = 4,
  localparam int ROW_W   = $clog2(NUM_ROWS + 1),
  localparam int COL_W   = $clog2(NUM_COLS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [COL_W-1:0]  inCol,
  input  logic              scrEn,
  input  logic              aisEn,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic [ROW_W-1:0]  outRow,
  output logic [COL_W-1:0]  outCol
);

  strobeT strb;

  sts1_scr_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .OH_COLS(OH_COLS), .PTR_ROW(PTR_ROW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inRow(inRow),
    .inCol(inCol), .scrEn(scrEn), .aisEn(aisEn), .strb(strb)
  );

  sts1_scr_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inByte(inByte),
    .inRow(inRow), .inCol(inCol), .outValid(outValid),
    .outByte(outByte), .outRow(outRow), .outCol(outCol)
  );

  // R6: one-cycle latency on valid
  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R4: transparent when neither function is on
  p_bypass_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !scrEn && !aisEn) |=> outByte == $past(inByte));

  // R3: framing and C1 bytes leave untouched
  p_framing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inRow == ROW_W'(1) && inCol <= COL_W'(OH_COLS))
      |=> outByte == $past(inByte));

  // R5: unscrambled AIS payload is all ones
  p_ais_payload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && aisEn && !scrEn && inCol > COL_W'(OH_COLS))
      |=> outByte == {BYTE_W{1'b1}});

endmodule

// File: tb/sim_sts1_tx_scrambler.sv
module sim_sts1_tx_scrambler;

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid;
  logic [7:0] inByte;
  logic [3:0] inRow;
  logic [6:0] inCol;
  logic       scrEn;
  logic       aisEn;
  logic       outValid;
  logic [7:0] outByte;
  logic [3:0] outRow;
  logic [6:0] outCol;

  always #10 clk = ~clk;  // 50 MHz

  sts1_tx_scrambler u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inRow(inRow), .inCol(inCol), .scrEn(scrEn), .aisEn(aisEn),
    .outValid(outValid), .outByte(outByte), .outRow(outRow), .outCol(outCol)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;
  bit  seqBits [0:126];
  int  bIdx = 0;

  typedef struct packed {
    logic [3:0] row;
    logic [6:0] col;
    logic [7:0] data;
    logic       scr;
    logic       ais;
    logic [7:0] exp;
  } vecT;

  // Frame start: framing/C1 untouched, restart, keystream FE 04 18 51 E4
  localparam vecT VECS [8] = '{
    '{4'd1, 7'd1, 8'hF6, 1'b1, 1'b1, 8'hF6},  // R3
    '{4'd1, 7'd2, 8'h28, 1'b1, 1'b1, 8'h28},  // R3
    '{4'd1, 7'd3, 8'h01, 1'b1, 1'b1, 8'h01},  // R3
    '{4'd1, 7'd4, 8'h00, 1'b1, 1'b0, 8'hFE},  // R2
    '{4'd1, 7'd5, 8'h00, 1'b1, 1'b0, 8'h04},  // R2
    '{4'd1, 7'd6, 8'h00, 1'b1, 1'b1, 8'hE7},  // R5 then R2 (FF^18)
    '{4'd1, 7'd7, 8'h3C, 1'b0, 1'b0, 8'h3C},  // R4, keystream 51 skipped
    '{4'd1, 7'd8, 8'h00, 1'b1, 1'b0, 8'hE4}   // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] keyByte(input int idx);
    logic [7:0] m;
    int p;
    p = (idx * 8) % 127;
    for (int k = 0; k < 8; k++) m[7-k] = seqBits[(p + k) % 127];
    return m;
  endfunction

  // Send one byte, then check it one clock later
  task automatic sendByte(input int r, input int c, input logic [7:0] d,
                          input logic s, input logic a,
                          input logic useTbl, input logic [7:0] tblExp);
    logic [7:0] exp;
    logic [7:0] base;
    @(negedge clk);
    inValid = 1'b1; inRow = 4'(r); inCol = 7'(c); inByte = d;
    scrEn = s; aisEn = a;
    if (r == 1 && c == 4) bIdx = 0;
    if (r == 1 && c <= 3) exp = d;
    else begin
      base = (a && (c > 3 || r == 4)) ? 8'hFF : d;
      exp  = s ? (base ^ keyByte(bIdx)) : base;
    end
    if (useTbl) exp = tblExp;
    bIdx++;
    @(posedge clk); #5;
    check("R6 valid", 32'(outValid), 32'd1);
    check("R6 tags", {21'd0, outRow, outCol}, {21'd0, 4'(r), 7'(c)});
    check("R1/R3/R4/R5 byte", 32'(outByte), 32'(exp));
  endtask

  task automatic idleCycle();
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); #5;
    check("R6 idle", 32'(outValid), 32'd0);
  endtask

  function automatic logic [7:0] pat(input int r, input int c, input int f);
    return 8'((r * 37) ^ (c * 11) ^ (f * 91) ^ 8'h5A);
  endfunction

  task automatic runFrame(input int f, input logic s, input logic a, input int gapEvery);
    int n;
    n = 0;
    for (int r = 1; r <= 9; r++)
      for (int c = 1; c <= 90; c++) begin
        sendByte(r, c, pat(r, c, f), s, a, 1'b0, 8'h00);
        n++;
        if (gapEvery > 0 && (n % gapEvery) == 0) begin
          idleCycle();
          idleCycle();  // R7: two idle cycles must not shift keystream
        end
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 7; n++) seqBits[n] = 1'b1;
    for (int n = 7; n < 127; n++) seqBits[n] = seqBits[n-6] ^ seqBits[n-7];

    rstN = 1'b0; inValid = 1'b0; inByte = 8'hA5; inRow = 4'd1; inCol = 7'd1;
    scrEn = 1'b1; aisEn = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check("R8 reset valid", 32'(outValid), 32'd0);
    check("R8 reset byte", 32'(outByte), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R8: scrambler comes out of reset at all ones
    sendByte(2, 5, 8'h00, 1'b1, 1'b0, 1'b1, 8'hFE);

    // Vector table at a frame start
    foreach (VECS[i])
      sendByte(int'(VECS[i].row), int'(VECS[i].col), VECS[i].data,
               VECS[i].scr, VECS[i].ais, 1'b1, VECS[i].exp);
    // Remainder of that frame scrambled
    for (int r = 1; r <= 9; r++)
      for (int c = 1; c <= 90; c++)
        if (!(r == 1 && c <= 8)) sendByte(r, c, pat(r, c, 0), 1'b1, 1'b0, 1'b0, 8'h00);

    runFrame(1, 1'b1, 1'b0, 0);   // R1, R2, R3 across a frame wrap
    runFrame(2, 1'b1, 1'b1, 0);   // R5 with scrambling
    runFrame(3, 1'b0, 1'b0, 0);   // R4 bypass
    runFrame(4, 1'b0, 1'b1, 0);   // R5 without scrambling
    runFrame(5, 1'b1, 1'b0, 97);  // R7 with idle gaps, R6 idle output

    // R3 corner: framing bytes with both features on
    sendByte(1, 1, 8'hF6, 1'b1, 1'b1, 1'b1, 8'hF6);
    sendByte(1, 3, 8'h7E, 1'b1, 1'b1, 1'b1, 8'h7E);
    idleCycle();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule